// File: doc/BRIEF.md
# Per-CPU Bus Interrupt Mailbox

This block gives every CPU a single-entry mailbox for interrupts that arrive from an external bus. Each incoming bus interrupt names a target CPU, carries a 5-bit source id and two 64-bit payload words. When the target's mailbox is empty the block captures the source id and both words, marks the mailbox busy, and posts one shared, software-programmed vector to that CPU. When the mailbox is already busy the interrupt is refused, and the sender has to retry later. Every interrupt gets a one-cycle accept or refuse response.

Software reaches the block through a simple register port. Each request carries the id of the issuing CPU. Payload words and busy/source status can be read at indexed addresses, one slot per CPU. They can also be read at alias addresses that resolve to the issuing CPU's own slot. A CPU frees its mailbox by writing a zero busy bit.

Top module: `bus_irq_mailbox`

## Requirements
- R1: After reset every busy bit, source id, payload word and the shared vector read as zero, and no response, post or read data is signalled.
- R2: An interrupt to a free mailbox is answered one cycle later with ack valid and accept=1. In the same cycle a post is signalled carrying the target CPU and the current shared vector.
- R3: An interrupt to a busy mailbox is answered with accept=0 and no post. The stored source id and payload words of that slot stay unchanged.
- R4: On acceptance the source id and both payload words are stored for the target CPU and read back from its indexed addresses.
- R5: The shared vector is 6 bits wide, taken from write data bits 5:0 and readable in the low bits. A post uses the vector value held at the moment of acceptance.
- R6: A status read returns busy in bit 5 and the source id in bits 4:0, with all other bits zero.
- R7: A status write changes only the busy bit, taken from data bit 5, and leaves the source id unchanged. Clearing busy lets the next interrupt to that CPU be accepted.
- R8: Alias addresses select the slot of the CPU given on the request's CPU id input, for payload word 0, payload word 1 and status reads, and for status writes.
- R9: When a status write and an accepted interrupt hit the same slot in one cycle, the acceptance wins: the slot ends busy with the new source id.
- R10: Read data is valid exactly two cycles after a read request. Reads of unmapped addresses return zero and writes to them change nothing. The byte address is {region[2:0], index[4:0], 3'b000}. The regions are 0 payload word 0, 1 payload word 1, 2 status, 3 alias and 4 vector, the vector sitting at index 0. Within the alias region, index 0 selects payload word 0, index 1 payload word 1 and index 2 status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bi_valid_i | input | 1 | Incoming bus interrupt present |
| bi_cpu_i | input | 5 | Target CPU of the interrupt |
| bi_src_i | input | 5 | Source id of the interrupt |
| bi_data0_i | input | 64 | Payload word 0 |
| bi_data1_i | input | 64 | Payload word 1 |
| bi_ack_valid_o | output | 1 | Response to an interrupt is present |
| bi_ack_accept_o | output | 1 | 1 = accepted, 0 = refused, retry later |
| post_valid_o | output | 1 | Vector post to a CPU |
| post_cpu_o | output | 5 | CPU receiving the post |
| post_vec_o | output | 6 | Vector being posted |
| reg_req_i | input | 1 | Register access request |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_cpu_i | input | 5 | Id of the CPU issuing the access |
| reg_addr_i | input | 11 | Byte address |
| reg_wdata_i | input | 64 | Write data |
| rd_valid_o | output | 1 | Read data valid |
| rd_data_o | output | 64 | Read data |

## Verification
The embedded assertions watch several rules on every cycle. No post appears without an accepting response, and a busy slot is never accepted. An acceptance always leaves its slot busy with the new source id, even against a colliding status write. The source id never moves without an acceptance, and every read returns data exactly two cycles later. The bench's scenarios are needed for the rest. These are the actual payload values, the status and vector bit layout, alias resolution to the requesting CPU, the vector used by a post after reprogramming, and the silence of unmapped addresses.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int SRC_W    = 5;
  localparam int VEC_W    = 6;
  localparam int BUSY_BIT = 5;
  localparam int NWORDS   = 2;

  typedef enum logic [2:0] {
    RG_WORD0 = 3'd0,
    RG_WORD1 = 3'd1,
    RG_STAT  = 3'd2,
    RG_ALIAS = 3'd3,
    RG_VEC   = 3'd4
  } mbx_region_e;

  typedef enum logic [2:0] {
    SEL_NONE  = 3'd0,
    SEL_WORD0 = 3'd1,
    SEL_WORD1 = 3'd2,
    SEL_STAT  = 3'd3,
    SEL_VEC   = 3'd4
  } mbx_sel_e;
endpackage

// File: rtl/mbx_data_ram.sv
module mbx_data_ram #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 64,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/mbx_reg_decode.sv
module mbx_reg_decode
  import mbx_pkg::*;
#(
  parameter int NUM_CPU = 32,
  localparam int IDX_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int ADDR_W = IDX_W + 6
) (
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [IDX_W-1:0]  cpu_id,
  output mbx_sel_e          sel,
  output logic [IDX_W-1:0]  slot,
  output logic              rd,
  output logic              wr_stat,
  output logic              wr_vec
);
  logic [2:0]       region;
  logic [IDX_W-1:0] idx;
  logic             idx_ok;

  assign region = addr[ADDR_W-1 -: 3];
  assign idx    = addr[3 +: IDX_W];
  assign idx_ok = int'(idx) < NUM_CPU;

  always_comb begin
    sel  = SEL_NONE;
    slot = idx;
    unique case (region)
      RG_WORD0: if (idx_ok) sel = SEL_WORD0;
      RG_WORD1: if (idx_ok) sel = SEL_WORD1;
      RG_STAT:  if (idx_ok) sel = SEL_STAT;
      RG_ALIAS: begin
        slot = cpu_id;
        if (int'(cpu_id) < NUM_CPU) begin
          if (int'(idx) == 0)      sel = SEL_WORD0;
          else if (int'(idx) == 1) sel = SEL_WORD1;
          else if (int'(idx) == 2) sel = SEL_STAT;
        end
      end
      RG_VEC:   if (int'(idx) == 0) sel = SEL_VEC;
      default:  sel = SEL_NONE;
    endcase
  end

  assign rd      = req && !we;
  assign wr_stat = req && we && (sel == SEL_STAT);
  assign wr_vec  = req && we && (sel == SEL_VEC);
endmodule

// File: rtl/mbx_slot_status.sv
module mbx_slot_status
  import mbx_pkg::*;
#(
  parameter int NUM_CPU = 32,
  localparam int IDX_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            acc_fire,
  input  logic [IDX_W-1:0]                acc_slot,
  input  logic [SRC_W-1:0]                acc_src,
  input  logic                            sw_we,
  input  logic [IDX_W-1:0]                sw_slot,
  input  logic                            sw_busy,
  output logic [NUM_CPU-1:0]              busy_q,
  output logic [NUM_CPU-1:0]              filled_q,
  output logic [NUM_CPU-1:0][SRC_W-1:0]   src_q
);
  for (genvar i = 0; i < NUM_CPU; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        busy_q[i]   <= 1'b0;
        filled_q[i] <= 1'b0;
        src_q[i]    <= '0;
      end else if (acc_fire && int'(acc_slot) == i) begin
        busy_q[i]   <= 1'b1;
        filled_q[i] <= 1'b1;
        src_q[i]    <= acc_src;
      end else if (sw_we && int'(sw_slot) == i) begin
        busy_q[i]   <= sw_busy;
      end
    end
  end

  assert_no_accept_busy_R3: assert property (@(posedge clk) disable iff (rst)
    acc_fire |-> !busy_q[acc_slot]);

  assert_accept_sets_busy_R4: assert property (@(posedge clk) disable iff (rst)
    acc_fire |=> busy_q[$past(acc_slot)]);

  assert_accept_wins_R9: assert property (@(posedge clk) disable iff (rst)
    (acc_fire && sw_we && sw_slot == acc_slot) |=>
      (busy_q[$past(acc_slot)] && src_q[$past(acc_slot)] == $past(acc_src)));

  assert_src_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !acc_fire |=> $stable(src_q));
endmodule

// File: rtl/bus_irq_mailbox.sv
module bus_irq_mailbox
  import mbx_pkg::*;
#(
  parameter int NUM_CPU = 32,
  parameter int DATA_W  = 64,
  localparam int IDX_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int ADDR_W = IDX_W + 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bi_valid_i,
  input  logic [IDX_W-1:0]  bi_cpu_i,
  input  logic [SRC_W-1:0]  bi_src_i,
  input  logic [DATA_W-1:0] bi_data0_i,
  input  logic [DATA_W-1:0] bi_data1_i,
  output logic              bi_ack_valid_o,
  output logic              bi_ack_accept_o,
  output logic              post_valid_o,
  output logic [IDX_W-1:0]  post_cpu_o,
  output logic [VEC_W-1:0]  post_vec_o,
  input  logic              reg_req_i,
  input  logic              reg_we_i,
  input  logic [IDX_W-1:0]  reg_cpu_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int PAD_STAT = DATA_W - SRC_W - 1;
  localparam int PAD_VEC  = DATA_W - VEC_W;

  mbx_sel_e                           dec_sel;
  logic [IDX_W-1:0]                   dec_slot;
  logic                               dec_rd, dec_wr_stat, dec_wr_vec;
  logic [NUM_CPU-1:0]                 busy_q, filled_q;
  logic [NUM_CPU-1:0][SRC_W-1:0]      src_q;
  logic                               acc_fire, cpu_ok;
  logic [VEC_W-1:0]                   vec_q;
  logic [NWORDS-1:0][DATA_W-1:0]      word_in, word_q;

  mbx_reg_decode #(.NUM_CPU(NUM_CPU)) u_dec (
    .req(reg_req_i), .we(reg_we_i), .addr(reg_addr_i), .cpu_id(reg_cpu_i),
    .sel(dec_sel), .slot(dec_slot), .rd(dec_rd),
    .wr_stat(dec_wr_stat), .wr_vec(dec_wr_vec)
  );

  assign cpu_ok   = int'(bi_cpu_i) < NUM_CPU;
  assign acc_fire = bi_valid_i && cpu_ok && !busy_q[bi_cpu_i];

  mbx_slot_status #(.NUM_CPU(NUM_CPU)) u_stat (
    .clk(clk), .rst(rst),
    .acc_fire(acc_fire), .acc_slot(bi_cpu_i), .acc_src(bi_src_i),
    .sw_we(dec_wr_stat), .sw_slot(dec_slot), .sw_busy(reg_wdata_i[BUSY_BIT]),
    .busy_q(busy_q), .filled_q(filled_q), .src_q(src_q)
  );

  assign word_in[0] = bi_data0_i;
  assign word_in[1] = bi_data1_i;

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    mbx_data_ram #(.DEPTH(NUM_CPU), .WIDTH(DATA_W)) u_ram (
      .clk(clk), .we(acc_fire), .waddr(bi_cpu_i), .wdata(word_in[w]),
      .raddr(dec_slot), .rdata(word_q[w])
    );
  end

  // Interrupt response and vector post
  always_ff @(posedge clk) begin
    if (rst) begin
      bi_ack_valid_o  <= 1'b0;
      bi_ack_accept_o <= 1'b0;
      post_valid_o    <= 1'b0;
      post_cpu_o      <= '0;
      post_vec_o      <= '0;
      vec_q           <= '0;
    end else begin
      bi_ack_valid_o  <= bi_valid_i;
      bi_ack_accept_o <= acc_fire;
      post_valid_o    <= acc_fire;
      if (acc_fire) begin
        post_cpu_o <= bi_cpu_i;
        post_vec_o <= vec_q;
      end
      if (dec_wr_vec) vec_q <= reg_wdata_i[VEC_W-1:0];
    end
  end

  // Two-stage read pipeline: stage 1 aligns with the RAM read register
  logic                rd_p1, filled_p1;
  mbx_sel_e            sel_p1;
  logic [SRC_W:0]      stat_p1;
  logic [VEC_W-1:0]    vec_p1;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_p1      <= 1'b0;
      sel_p1     <= SEL_NONE;
      stat_p1    <= '0;
      vec_p1     <= '0;
      filled_p1  <= 1'b0;
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_p1      <= dec_rd;
      sel_p1     <= dec_rd ? dec_sel : SEL_NONE;
      stat_p1    <= {busy_q[dec_slot], src_q[dec_slot]};
      vec_p1     <= vec_q;
      filled_p1  <= filled_q[dec_slot];
      rd_valid_o <= rd_p1;
      unique case (sel_p1)
        SEL_WORD0: rd_data_o <= filled_p1 ? word_q[0] : '0;
        SEL_WORD1: rd_data_o <= filled_p1 ? word_q[1] : '0;
        SEL_STAT:  rd_data_o <= {{PAD_STAT{1'b0}}, stat_p1};
        SEL_VEC:   rd_data_o <= {{PAD_VEC{1'b0}}, vec_p1};
        default:   rd_data_o <= '0;
      endcase
    end
  end

  assert_post_needs_accept_R2: assert property (@(posedge clk) disable iff (rst)
    post_valid_o |-> (bi_ack_valid_o && bi_ack_accept_o));

  assert_refuse_busy_R3: assert property (@(posedge clk) disable iff (rst)
    (bi_valid_i && busy_q[bi_cpu_i]) |=>
      (bi_ack_valid_o && !bi_ack_accept_o && !post_valid_o));

  assert_rd_latency_R10: assert property (@(posedge clk) disable iff (rst)
    (reg_req_i && !reg_we_i) |=> ##1 rd_valid_o);
endmodule

// File: tb/bus_irq_mailbox_tb_top.sv
module bus_irq_mailbox_tb_top;
  localparam int NT = 6;
  // {cpu[4:0], src[4:0], seed[7:0], expect_accept}
  localparam logic [18:0] TBL [NT] = '{
    {5'd3,  5'd7,  8'h11, 1'b1},
    {5'd3,  5'd9,  8'h22, 1'b0},
    {5'd0,  5'd31, 8'h33, 1'b1},
    {5'd31, 5'd1,  8'h44, 1'b1},
    {5'd31, 5'd12, 8'h55, 1'b0},
    {5'd17, 5'd0,  8'h66, 1'b1}
  };

  logic        clk = 0, rst = 1;
  logic        bi_valid = 0;
  logic [4:0]  bi_cpu = 0, bi_src = 0;
  logic [63:0] bi_d0 = 0, bi_d1 = 0;
  logic        ack_valid, ack_accept, post_valid;
  logic [4:0]  post_cpu;
  logic [5:0]  post_vec;
  logic        req = 0, we = 0;
  logic [4:0]  rcpu = 0;
  logic [10:0] addr = 0;
  logic [63:0] wdata = 0;
  logic        rd_valid;
  logic [63:0] rd_data;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bus_irq_mailbox dut_i (
    .clk(clk), .rst(rst),
    .bi_valid_i(bi_valid), .bi_cpu_i(bi_cpu), .bi_src_i(bi_src),
    .bi_data0_i(bi_d0), .bi_data1_i(bi_d1),
    .bi_ack_valid_o(ack_valid), .bi_ack_accept_o(ack_accept),
    .post_valid_o(post_valid), .post_cpu_o(post_cpu), .post_vec_o(post_vec),
    .reg_req_i(req), .reg_we_i(we), .reg_cpu_i(rcpu), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .rd_valid_o(rd_valid), .rd_data_o(rd_data)
  );

  function automatic logic [10:0] ad(input int region, input int idx);
    return {region[2:0], idx[4:0], 3'b000};
  endfunction
  function automatic logic [63:0] w0(input logic [7:0] s);
    return {8{s}};
  endfunction
  function automatic logic [63:0] w1(input logic [7:0] s);
    return {4{s, 8'hA5}};
  endfunction

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic send(input int cpu, input int src, input logic [7:0] s);
    @(negedge clk);
    bi_valid = 1; bi_cpu = cpu[4:0]; bi_src = src[4:0];
    bi_d0 = w0(s); bi_d1 = w1(s);
    @(negedge clk);
    bi_valid = 0;
  endtask

  task automatic rd(input int cpu, input logic [10:0] a, output logic [63:0] d);
    @(negedge clk);
    req = 1; we = 0; rcpu = cpu[4:0]; addr = a;
    @(negedge clk);
    req = 0;
    @(negedge clk);
    chk("R10 rd_valid", {63'd0, rd_valid}, 64'd1);
    d = rd_data;
  endtask

  task automatic wr(input int cpu, input logic [10:0] a, input logic [63:0] d);
    @(negedge clk);
    req = 1; we = 1; rcpu = cpu[4:0]; addr = a; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 ack_valid", {63'd0, ack_valid}, 0);
    chk("R1 post_valid", {63'd0, post_valid}, 0);
    chk("R1 rd_valid", {63'd0, rd_valid}, 0);
    rd(0, ad(2, 5), d); chk("R1 status", d, 0);
    rd(0, ad(4, 0), d); chk("R1 vector", d, 0);
    rd(0, ad(0, 8), d); chk("R1 word0", d, 0);

    // R5 vector programming: only bits 5:0 kept
    wr(0, ad(4, 0), 64'hFFFF_FFC0_0000_00EA);
    rd(0, ad(4, 0), d); chk("R5 vector readback", d, 64'h2A);

    // R2/R3 table of interrupts
    for (int k = 0; k < NT; k++) begin
      logic [4:0] c, s; logic [7:0] sd; logic e;
      {c, s, sd, e} = TBL[k];
      send(int'(c), int'(s), sd);
      chk("R2 ack_valid", {63'd0, ack_valid}, 1);
      chk("R2/R3 accept", {63'd0, ack_accept}, {63'd0, e});
      chk("R2/R3 post_valid", {63'd0, post_valid}, {63'd0, e});
      if (e) begin
        chk("R2 post_cpu", {59'd0, post_cpu}, {59'd0, c});
        chk("R2 post_vec", {58'd0, post_vec}, 64'h2A);
      end
    end

    // R4 stored data, R3 refused data not stored
    rd(0, ad(0, 3), d); chk("R4/R3 word0 cpu3", d, w0(8'h11));
    rd(0, ad(1, 3), d); chk("R4/R3 word1 cpu3", d, w1(8'h11));
    rd(0, ad(0, 17), d); chk("R4 word0 cpu17", d, w0(8'h66));
    // R6 status layout
    rd(0, ad(2, 3), d); chk("R6 status cpu3", d, 64'h27);
    rd(0, ad(2, 0), d); chk("R6 status cpu0", d, 64'h3F);

    // R8 aliases from requester 31
    rd(31, ad(3, 0), d); chk("R8 alias word0", d, w0(8'h44));
    rd(31, ad(3, 1), d); chk("R8 alias word1", d, w1(8'h44));
    rd(31, ad(3, 2), d); chk("R8 alias status", d, 64'h21);
    wr(31, ad(3, 2), 64'h0);
    rd(0, ad(2, 31), d); chk("R8 alias status write", d, 64'h01);

    // R7 busy-only write, then re-accept
    wr(0, ad(2, 3), 64'hFFFF_FFFF_FFFF_FFDF);
    rd(0, ad(2, 3), d); chk("R7 busy cleared src kept", d, 64'h07);
    send(3, 2, 8'h77);
    chk("R7 reaccept", {63'd0, ack_accept}, 1);
    rd(0, ad(2, 3), d); chk("R7 new status", d, 64'h22);

    // R9 same-cycle status write and acceptance on cpu 9
    @(negedge clk);
    bi_valid = 1; bi_cpu = 9; bi_src = 4; bi_d0 = w0(8'h99); bi_d1 = w1(8'h99);
    req = 1; we = 1; rcpu = 0; addr = ad(2, 9); wdata = 64'h0;
    @(negedge clk);
    bi_valid = 0; req = 0; we = 0;
    chk("R9 accept", {63'd0, ack_accept}, 1);
    rd(0, ad(2, 9), d); chk("R9 accept wins", d, 64'h24);

    // R5 post uses the vector held at acceptance
    wr(0, ad(4, 0), 64'hD5);
    rd(0, ad(4, 0), d); chk("R5 vector readback 2", d, 64'h15);
    send(20, 3, 8'h20);
    chk("R5 post_vec new", {58'd0, post_vec}, 64'h15);

    // R10 unmapped accesses and latency
    rd(0, ad(5, 1), d); chk("R10 unmapped read", d, 0);
    wr(0, ad(6, 0), 64'h3F);
    rd(0, ad(4, 0), d); chk("R10 unmapped write ignored", d, 64'h15);
    @(negedge clk);
    req = 1; we = 0; addr = ad(4, 0);
    @(negedge clk);
    req = 0;
    chk("R10 not valid after one cycle", {63'd0, rd_valid}, 0);
    @(negedge clk);
    chk("R10 valid after two cycles", {63'd0, rd_valid}, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule